// File: doc/BRIEF.md
# Concurrent Kernel Block Dispatcher

This block hands out thread blocks from up to `NK` pending kernels to an array of `NSM` multiprocessor slots, launching at most one block per cycle. A kernel is registered by writing a kernel-source slot with its kernel ID and block count. The dispatcher then launches that many blocks through a valid/ready output. Each launch carries the kernel ID, a block index and the target multiprocessor. Each multiprocessor is modelled only as a resident-block counter: a launch increments it and a retire pulse on that multiprocessor's line decrements it.

A multiprocessor is bound to one kernel while it holds any block. Different kernels therefore run side by side only on separate multiprocessors, while one large kernel may spread across many of them. A multiprocessor becomes free for any kernel once its resident count falls back to zero. When the last outstanding block of a kernel retires, the dispatcher pulses a per-slot done flag, and the slot can then be loaded again.

Top module: `kblock_dispatch`

## Requirements
- R1: After reset, `o_valid` and every bit of `done_o` are 0.
- R2: No multiprocessor holds more than `MAXRES` (8) unretired blocks; once one is full, further blocks of its kernel go to another multiprocessor.
- R3: All blocks resident on one multiprocessor carry the same kernel ID.
- R4: The target is the lowest-indexed multiprocessor already bound to the same kernel with room; if there is none, it is the lowest-indexed empty multiprocessor.
- R5: When several slots hold blocks still to launch and can be placed, the lowest-numbered slot is served first.
- R6: A kernel loaded with N blocks produces exactly N launches, with block indices N-1 down to 0 in that order.
- R7: A multiprocessor whose resident count returns to zero may receive blocks of a different kernel.
- R8: `done_o[k]` is high for exactly one cycle, the cycle after the edge at which the last outstanding block of slot k retired.
- R9: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_kid`, `o_blk` and `o_sm` hold their values.
- R10: A load into a slot that still has blocks to launch or unretired blocks is ignored, and a load with a zero block count is ignored. Neither produces a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe for a kernel-source slot |
| ld_slot | input | $clog2(NK) | Slot being loaded |
| ld_kid | input | KIDW | Kernel ID for the slot |
| ld_blocks | input | CW | Number of blocks in the kernel |
| ret_i | input | NSM | One retire pulse bit per multiprocessor |
| o_valid | output | 1 | Launch offered |
| o_ready | input | 1 | Launch accepted when high together with o_valid |
| o_kid | output | KIDW | Kernel ID of the launched block |
| o_blk | output | CW | Block index |
| o_sm | output | $clog2(NSM) | Target multiprocessor |
| done_o | output | NK | One-cycle completion pulse per slot |

## Verification
A corrupted resident count shows at the ports as a launch to a multiprocessor that already has eight blocks, or as a multiprocessor that is skipped although it is empty. Either appears at the very next placement. A wrong binding shows as two kernel IDs launched to the same multiprocessor. A miscounted outstanding total shows as a done pulse that comes early, comes late or never comes, relative to the final retire pulse. A held launch that changes under backpressure shows on the output fields in the following cycle.

// File: rtl/kblock_dispatch.sv
module kblock_dispatch #(
  parameter int NSM    = 16,
  parameter int NK     = 16,
  parameter int MAXRES = 8,
  parameter int KIDW   = 8,
  parameter int CW     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  input  logic [$clog2(NK)-1:0]   ld_slot,
  input  logic [KIDW-1:0]         ld_kid,
  input  logic [CW-1:0]           ld_blocks,
  input  logic [NSM-1:0]          ret_i,
  output logic                    o_valid,
  input  logic                    o_ready,
  output logic [KIDW-1:0]         o_kid,
  output logic [CW-1:0]           o_blk,
  output logic [$clog2(NSM)-1:0]  o_sm,
  output logic [NK-1:0]           done_o
);
  localparam int SMW = $clog2(NSM);
  localparam int KSW = $clog2(NK);
  localparam int RW  = $clog2(MAXRES + 1);
  localparam int OW  = $clog2(NSM * MAXRES + 1);
  localparam logic [RW-1:0] RMAX = RW'(MAXRES);

  logic [RW-1:0]   res  [NSM];
  logic [KSW-1:0]  bnd  [NSM];
  logic [CW-1:0]   rem  [NK];
  logic [OW-1:0]   outs [NK];
  logic [KIDW-1:0] kid  [NK];

  logic [RW-1:0]   res_n  [NSM];
  logic [KSW-1:0]  bnd_n  [NSM];
  logic [CW-1:0]   rem_n  [NK];
  logic [OW-1:0]   outs_n [NK];
  logic [NK-1:0]   done_n;

  logic            sel_found;
  logic [KSW-1:0]  sel_k;
  logic [SMW-1:0]  sel_sm;
  logic            take;
  logic            ld_ok;

  always_comb begin
    logic           hit;
    logic [SMW-1:0] pick;
    sel_found = 1'b0;
    sel_k     = '0;
    sel_sm    = '0;
    for (int k = NK - 1; k >= 0; k--) begin
      hit  = 1'b0;
      pick = '0;
      for (int s = NSM - 1; s >= 0; s--)
        if (res[s] == '0) begin hit = 1'b1; pick = SMW'(s); end
      for (int s = NSM - 1; s >= 0; s--)
        if (res[s] != '0 && res[s] < RMAX && bnd[s] == KSW'(k)) begin
          hit = 1'b1; pick = SMW'(s);
        end
      if (rem[k] != '0 && hit) begin
        sel_found = 1'b1; sel_k = KSW'(k); sel_sm = pick;
      end
    end
  end

  assign take  = (!o_valid || o_ready) && sel_found;
  assign ld_ok = ld_valid && ld_blocks != '0 && rem[ld_slot] == '0 && outs[ld_slot] == '0;

  always_comb begin
    res_n  = res;
    bnd_n  = bnd;
    rem_n  = rem;
    outs_n = outs;
    for (int s = 0; s < NSM; s++)
      if (ret_i[s] && res[s] != '0) begin
        res_n[s]        = res_n[s] - RW'(1);
        outs_n[bnd[s]]  = outs_n[bnd[s]] - OW'(1);
      end
    if (take) begin
      res_n[sel_sm]  = res_n[sel_sm] + RW'(1);
      bnd_n[sel_sm]  = sel_k;
      outs_n[sel_k]  = outs_n[sel_k] + OW'(1);
      rem_n[sel_k]   = rem_n[sel_k] - CW'(1);
    end
    if (ld_ok) rem_n[ld_slot] = ld_blocks;
    for (int k = 0; k < NK; k++)
      done_n[k] = rem_n[k] == '0 && outs[k] != '0 && outs_n[k] == '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_kid   <= '0;
      o_blk   <= '0;
      o_sm    <= '0;
      done_o  <= '0;
      for (int s = 0; s < NSM; s++) begin res[s] <= '0; bnd[s] <= '0; end
      for (int k = 0; k < NK; k++) begin rem[k] <= '0; outs[k] <= '0; kid[k] <= '0; end
    end else begin
      res    <= res_n;
      bnd    <= bnd_n;
      rem    <= rem_n;
      outs   <= outs_n;
      done_o <= done_n;
      if (ld_ok) kid[ld_slot] <= ld_kid;
      if (!o_valid || o_ready) begin
        o_valid <= sel_found;
        if (sel_found) begin
          o_kid <= kid[sel_k];
          o_blk <= rem[sel_k] - CW'(1);
          o_sm  <= sel_sm;
        end
      end
    end
  end

  AST_HOLD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_kid) && $stable(o_blk) && $stable(o_sm)); // R9

  AST_LAUNCH_BINDING: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> kid[bnd[o_sm]] == o_kid && res[o_sm] != '0); // R3

  generate
    for (genvar s = 0; s < NSM; s++) begin : g_sm_chk
      AST_RES_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        res[s] <= RMAX); // R2
    end
    for (genvar k = 0; k < NK; k++) begin : g_k_chk
      AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o[k] |-> rem[k] == '0 && outs[k] == '0); // R8
      AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o[k] |=> !done_o[k]); // R8
    end
  endgenerate
endmodule

// File: tb/kblock_dispatch_tb.sv
module kblock_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSM = 16, NK = 16, KIDW = 8, CW = 12;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0;
  logic [3:0] ld_slot = 0;
  logic [KIDW-1:0] ld_kid = 0;
  logic [CW-1:0] ld_blocks = 0;
  logic [NSM-1:0] ret_i = 0;
  logic o_valid, o_ready = 1;
  logic [KIDW-1:0] o_kid;
  logic [CW-1:0] o_blk;
  logic [3:0] o_sm;
  logic [NK-1:0] done_o;

  int errors = 0, checks = 0;
  int nl = 0;
  int lk [256], lb [256], ls [256];
  int dcnt [NK];

  always #(CLK_PERIOD/2) clk = ~clk;

  kblock_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_kid(ld_kid),
    .ld_blocks(ld_blocks), .ret_i(ret_i), .o_valid(o_valid), .o_ready(o_ready),
    .o_kid(o_kid), .o_blk(o_blk), .o_sm(o_sm), .done_o(done_o));

  initial for (int k = 0; k < NK; k++) dcnt[k] = 0;

  always @(negedge clk) begin
    if (rst_n && o_valid && o_ready && nl < 256) begin
      lk[nl] = o_kid; lb[nl] = o_blk; ls[nl] = o_sm; nl = nl + 1;
    end
    for (int k = 0; k < NK; k++) if (done_o[k]) dcnt[k] = dcnt[k] + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int slot, input int id, input int n);
    @(negedge clk);
    ld_valid = 1; ld_slot = 4'(slot); ld_kid = KIDW'(id); ld_blocks = CW'(n);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic retire(input int sm, input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk); ret_i[sm] = 1;
      @(negedge clk); ret_i[sm] = 0;
    end
  endtask

  task automatic t_reset();
    chk(o_valid == 0, "R1 valid", o_valid, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
  endtask

  task automatic t_basic_done();
    int base = nl;
    int d0 = dcnt[0];
    load(0, 5, 3);
    tick(6);
    chk(nl - base == 3, "R6 launch count", nl - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk(lb[base+i] == 2 - i, "R6 block index", lb[base+i], 2 - i);
      chk(ls[base+i] == 0 && lk[base+i] == 5, "R4 same sm", ls[base+i], 0);
    end
    retire(0, 2);
    chk(dcnt[0] == d0, "R8 no early done", dcnt[0], d0);
    @(negedge clk); ret_i[0] = 1;
    @(negedge clk); ret_i[0] = 0;
    chk(done_o[0] == 1, "R8 done pulse", done_o[0], 1);
    @(negedge clk);
    chk(done_o[0] == 0, "R8 done width", done_o[0], 0);
  endtask

  task automatic t_fill();
    int base = nl;
    int d0 = dcnt[0];
    int bad = 0;
    load(0, 3, 20);
    tick(25);
    chk(nl - base == 20, "R6 fill count", nl - base, 20);
    for (int i = 0; i < 20; i++) begin
      int e = (i < 8) ? 0 : (i < 16) ? 1 : 2;
      if (ls[base+i] != e || lb[base+i] != 19 - i) bad++;
    end
    chk(bad == 0, "R2 spill to next sm", bad, 0);
    retire(0, 8); retire(1, 8); retire(2, 4);
    tick(2);
    chk(dcnt[0] == d0 + 1, "R8 fill done", dcnt[0], d0 + 1);
  endtask

  task automatic t_two_kernels();
    int base = nl;
    int d1 = dcnt[1], d2 = dcnt[2];
    int ek [5] = '{9, 7, 7, 9, 9};
    int es [5] = '{0, 1, 1, 0, 0};
    int eb [5] = '{2, 1, 0, 1, 0};
    int bad = 0, n4 = 0;
    o_ready = 0;
    load(2, 9, 3);
    tick(2);
    chk(o_valid == 1 && o_kid == 9 && o_sm == 0 && o_blk == 2, "R9 held offer", o_kid, 9);
    load(1, 7, 2);
    load(2, 4, 5);
    load(3, 6, 0);
    tick(3);
    chk(o_valid == 1 && o_kid == 9 && o_sm == 0 && o_blk == 2, "R9 still held", o_blk, 2);
    o_ready = 1;
    tick(10);
    chk(nl - base == 5, "R10 ignored loads", nl - base, 5);
    for (int i = 0; i < 5 && base + i < nl; i++) begin
      if (lk[base+i] != ek[i] || ls[base+i] != es[i] || lb[base+i] != eb[i]) bad++;
      if (lk[base+i] == 4 || lk[base+i] == 6) n4++;
    end
    chk(bad == 0, "R5 R3 launch order", bad, 0);
    chk(n4 == 0, "R10 no launch from rejected load", n4, 0);
    retire(1, 2);
    tick(1);
    chk(dcnt[1] == d1 + 1, "R8 slot1 done", dcnt[1], d1 + 1);
    base = nl;
    load(4, 12, 1);
    tick(4);
    chk(nl - base == 1 && ls[base] == 1 && lk[base] == 12, "R7 reuse freed sm", ls[base], 1);
    retire(0, 3);
    retire(1, 1);
    tick(2);
    chk(dcnt[2] == d2 + 1, "R8 slot2 done", dcnt[2], d2 + 1);
    chk(dcnt[3] == 0, "R10 zero load no done", dcnt[3], 0);
    chk(o_valid == 0, "R6 idle after all", o_valid, 0);
  endtask

  initial begin
    fork
      begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_basic_done();
        t_fill();
        t_two_kernels();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule